// File: doc/BRIEF.md
# Smartcard Half-Duplex Character Transmitter

This block sends bytes to a smartcard over a single shared data line while supplying the card with its bit clock. Software queues bytes in a small transmit FIFO. When the smartcard mode enable is high, the block drives a continuous bit clock. It then sends each queued byte as a 12-bit character: one low start bit, eight data bits (least significant first), an even parity bit and two stop bits. The data line is open-drain. The block only ever pulls the line low, and it releases the line for every one bit, including both stop bits.

The card reports a parity error by holding the line low during the second stop bit. The block samples the line at the middle of that bit. If the line is low there, the block stops the transfer at once and flushes the FIFO, so every queued byte is discarded. It then raises a sticky parity-error interrupt. Software clears that interrupt with a pulse and decides what to resend; the block never retries on its own. Writes are refused during the flush cycle and accepted again right after it.

Top module: `sc_tx`

## Requirements
- R1: Out of reset `line_oe`, `bclk_out` and `perr_irq` are 0, and `wr_ready` is 1.
- R2: While `sc_en` is 1, `bclk_out` toggles every `BCLK_HALF` clock cycles. While `sc_en` is 0, `bclk_out` stays 0 and no character starts, but queued bytes are kept and are sent once `sc_en` rises.
- R3: Each character, in line order, is: a start bit of 0, data bits 0 to 7, a parity bit equal to the XOR of the data byte (even parity), and two stop bits of 1. The character is always 12 bits long; there is no stop-bit setting.
- R4: Every bit lasts `ETU_BCLKS` bit-clock periods, which is `2*BCLK_HALF*ETU_BCLKS` clock cycles.
- R5: Bytes leave the FIFO in write order. When `FIFO_DEPTH` bytes are queued, `wr_ready` is 0, and a write made then is dropped.
- R6: `line_oe` is 1 (line pulled low) only while a 0 bit is being sent. It is 0 during both stop bits and while idle.
- R7: The line is sampled once per character, `ETU_BCLKS/2` bit-clock periods into the second stop bit. A low there is a parity error. A low at any other time, such as during the first stop bit, has no effect.
- R8: On a parity error the character is abandoned and every byte still queued is discarded. No further character is sent until new data is written.
- R9: A parity error sets `perr_irq`, which stays 1 until a pulse on `irq_clr`. The block never resends a byte by itself.
- R10: `wr_ready` is 0 in the single flush cycle, and a write made in that cycle is ignored. From the next cycle writes are accepted again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sc_en | input | 1 | Smartcard mode enable; runs the bit clock and the transmitter |
| wr_en | input | 1 | Write strobe for the transmit FIFO |
| wr_data | input | 8 | Byte to queue |
| wr_ready | output | 1 | FIFO accepts a write this cycle |
| irq_clr | input | 1 | Pulse that clears the parity-error interrupt |
| line_in | input | 1 | Sensed level of the shared data line |
| line_oe | output | 1 | 1 pulls the shared data line low; 0 releases it |
| bclk_out | output | 1 | Bit clock for the card |
| perr_irq | output | 1 | Sticky parity-error interrupt |

## Verification
The bench builds the block with a FIFO depth of 4, a bit-clock half period of 2 cycles and 4 bit-clock periods per bit. Each bit is therefore 16 cycles and each character 192 cycles. This lets a bench of a few thousand cycles fill the FIFO to full, watch several back-to-back characters, and hit the exact error-sampling cycle. It places card pulls in the first and in the second stop bit to show that only the mid-point of the second stop bit counts. It also writes during the one flush cycle to show that this write is dropped.

// File: rtl/sc_tx_pkg.sv
package sc_tx_pkg;

    localparam int BYTE_W     = 8;
    localparam int FRAME_BITS = 12;   // start + 8 data + parity + 2 stop

    // Character laid out so that bit 0 goes on the line first.
    typedef struct packed {
        logic [1:0]        stop;
        logic              par;
        logic [BYTE_W-1:0] data;
        logic              start;
    } frame_t;

    function automatic frame_t build_frame(input logic [BYTE_W-1:0] b);
        frame_t f;
        f.stop  = 2'b11;
        f.par   = ^b;          // even parity
        f.data  = b;
        f.start = 1'b0;
        return f;
    endfunction

endpackage

// File: rtl/sc_tx_fifo.sv
module sc_tx_fifo #(
    parameter int DEPTH = 8,
    parameter int WIDTH = 8,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    input  logic             flush,
    output logic [WIDTH-1:0] dout,
    output logic [CW-1:0]    count
);
    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_ptr, rd_ptr;
    logic             push_ok, pop_ok;

    assign push_ok = push && (count != CW'(DEPTH));
    assign pop_ok  = pop && (count != '0);
    assign dout    = mem[rd_ptr];

    function automatic logic [AW-1:0] next_ptr(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok) wr_ptr <= next_ptr(wr_ptr);
            if (pop_ok)  rd_ptr <= next_ptr(rd_ptr);
            count <= count + CW'(push_ok) - CW'(pop_ok);
        end
    end
endmodule

// File: rtl/sc_tx_bitclk.sv
module sc_tx_bitclk #(
    parameter int HALF  = 4,
    localparam int HCW  = (HALF > 1) ? $clog2(HALF) : 1
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    output logic bclk,
    output logic rise    // high in the cycle before bclk goes high
);
    logic [HCW-1:0] cnt;
    logic           wrap;

    assign wrap = (cnt == HCW'(HALF - 1));
    assign rise = en && wrap && !bclk;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            cnt  <= '0;
            bclk <= 1'b0;
        end else if (wrap) begin
            cnt  <= '0;
            bclk <= ~bclk;
        end else begin
            cnt <= cnt + HCW'(1);
        end
    end
endmodule

// File: rtl/sc_tx_framer.sv
module sc_tx_framer
    import sc_tx_pkg::*;
#(
    parameter int ETU   = 372,
    localparam int ECW  = $clog2(ETU),
    localparam int MID  = ETU / 2 - 1,
    localparam int LAST = ETU - 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              rise,
    input  logic              fifo_empty,
    input  logic [BYTE_W-1:0] fifo_data,
    input  logic              line_in,
    output logic              pop,
    output logic              line_oe,
    output logic              flush
);
    frame_t         shreg;
    logic [3:0]     bit_idx;
    logic [ECW-1:0] etu_cnt;
    logic           active;
    logic           err_pt;

    assign pop = rise && en && !active && !fifo_empty && !flush;

    // Card error check: mid-point of the last stop bit.
    assign err_pt = active && rise && (bit_idx == 4'(FRAME_BITS - 1))
                    && (etu_cnt == ECW'(MID)) && !line_in;

    assign line_oe = active && !shreg.start;

    always_ff @(posedge clk) begin
        if (rst) begin
            active  <= 1'b0;
            shreg   <= '1;
            bit_idx <= '0;
            etu_cnt <= '0;
            flush   <= 1'b0;
        end else begin
            flush <= err_pt;
            if (!en) begin
                active  <= 1'b0;
                etu_cnt <= '0;
            end else if (pop) begin
                active  <= 1'b1;
                shreg   <= build_frame(fifo_data);
                bit_idx <= '0;
                etu_cnt <= '0;
            end else if (active) begin
                if (err_pt) begin
                    active <= 1'b0;
                end else if (rise) begin
                    if (etu_cnt == ECW'(LAST)) begin
                        etu_cnt <= '0;
                        if (bit_idx == 4'(FRAME_BITS - 1)) begin
                            active <= 1'b0;
                        end else begin
                            bit_idx <= bit_idx + 4'd1;
                            shreg   <= {1'b1, shreg[FRAME_BITS-1:1]};
                        end
                    end else begin
                        etu_cnt <= etu_cnt + ECW'(1);
                    end
                end
            end
        end
    end
endmodule

// File: rtl/sc_tx.sv
module sc_tx
    import sc_tx_pkg::*;
#(
    parameter int FIFO_DEPTH = 8,
    parameter int BCLK_HALF  = 4,
    parameter int ETU_BCLKS  = 372,
    localparam int CNT_W     = $clog2(FIFO_DEPTH + 1)
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       sc_en,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    output logic       wr_ready,
    input  logic       irq_clr,
    input  logic       line_in,
    output logic       line_oe,
    output logic       bclk_out,
    output logic       perr_irq
);
    logic [CNT_W-1:0]  fifo_count;
    logic [BYTE_W-1:0] fifo_dout;
    logic              fifo_empty, fifo_full;
    logic              pop, flush, rise;

    assign fifo_empty = (fifo_count == '0);
    assign fifo_full  = (fifo_count == CNT_W'(FIFO_DEPTH));
    assign wr_ready   = !fifo_full && !flush;

    sc_tx_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(BYTE_W)) u_fifo (
        .clk   (clk),
        .rst   (rst),
        .push  (wr_en && wr_ready),
        .din   (wr_data),
        .pop   (pop),
        .flush (flush),
        .dout  (fifo_dout),
        .count (fifo_count)
    );

    sc_tx_bitclk #(.HALF(BCLK_HALF)) u_bclk (
        .clk  (clk),
        .rst  (rst),
        .en   (sc_en),
        .bclk (bclk_out),
        .rise (rise)
    );

    sc_tx_framer #(.ETU(ETU_BCLKS)) u_frm (
        .clk        (clk),
        .rst        (rst),
        .en         (sc_en),
        .rise       (rise),
        .fifo_empty (fifo_empty),
        .fifo_data  (fifo_dout),
        .line_in    (line_in),
        .pop        (pop),
        .line_oe    (line_oe),
        .flush      (flush)
    );

    always_ff @(posedge clk) begin
        if (rst)          perr_irq <= 1'b0;
        else if (flush)   perr_irq <= 1'b1;
        else if (irq_clr) perr_irq <= 1'b0;
    end
endmodule

// File: rtl/sc_tx_chk.sv
module sc_tx_chk #(
    parameter int DEPTH = 8,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst,
    input logic          sc_en,
    input logic          bclk_out,
    input logic          line_oe,
    input logic          line_in,
    input logic          perr_irq,
    input logic          irq_clr,
    input logic          flush,
    input logic [CW-1:0] fifo_count
);
    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (!perr_irq && !line_oe && !bclk_out));

    a_r2_clock_parked: assert property (@(posedge clk) disable iff (rst)
        !sc_en |=> !bclk_out);

    a_r5_no_overflow: assert property (@(posedge clk) disable iff (rst)
        fifo_count <= CW'(DEPTH));

    a_r7_flush_needs_low: assert property (@(posedge clk) disable iff (rst)
        flush |-> !$past(line_in));

    a_r8_flush_empties: assert property (@(posedge clk) disable iff (rst)
        flush |=> (fifo_count == '0));

    a_r9_irq_sticky: assert property (@(posedge clk) disable iff (rst)
        (perr_irq && !irq_clr) |=> perr_irq);

    a_r9_irq_cause: assert property (@(posedge clk) disable iff (rst)
        $rose(perr_irq) |-> $past(flush));
endmodule

bind sc_tx sc_tx_chk #(.DEPTH(FIFO_DEPTH)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .sc_en      (sc_en),
    .bclk_out   (bclk_out),
    .line_oe    (line_oe),
    .line_in    (line_in),
    .perr_irq   (perr_irq),
    .irq_clr    (irq_clr),
    .flush      (flush),
    .fifo_count (fifo_count)
);

// File: tb/sc_tx_tb_top.sv
`timescale 1ns/1ps
module sc_tx_tb_top;
    localparam int DEPTH = 4;
    localparam int HALF  = 2;
    localparam int ETU   = 4;
    localparam int BIT   = 2 * HALF * ETU;   // 16 cycles
    localparam int FRAME = 12 * BIT;         // 192 cycles

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sc_en = 1'b0, wr_en = 1'b0, irq_clr = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic wr_ready, line_oe, bclk_out, perr_irq, line_in;
    logic card_pull = 1'b0;

    int checks = 0, errors = 0;
    bit done = 1'b0;

    // Values captured inside the receive loop.
    logic [11:0] bits;
    logic oe15, oe16, irq183, irq185, rdy184, rdy185;

    always #10 clk = ~clk;   // 50 MHz

    assign line_in = !(line_oe || card_pull);

    sc_tx #(.FIFO_DEPTH(DEPTH), .BCLK_HALF(HALF), .ETU_BCLKS(ETU)) dut_i (
        .clk(clk), .rst(rst), .sc_en(sc_en), .wr_en(wr_en), .wr_data(wr_data),
        .wr_ready(wr_ready), .irq_clr(irq_clr), .line_in(line_in),
        .line_oe(line_oe), .bclk_out(bclk_out), .perr_irq(perr_irq)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic put(input logic [7:0] b);
        @(negedge clk);
        wr_en = 1'b1; wr_data = b;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Waits for a start bit, then samples all 12 bits at their middles.
    // pull_bit >= 0 makes the card hold the line low inside that bit.
    // A write of poke_byte is issued in the flush cycle when poke is set.
    task automatic recv(input int pull_bit, input bit poke, input logic [7:0] poke_byte,
                        output bit seen);
        int waited = 0;
        seen = 1'b0;
        while (!line_oe && waited < 2000) begin
            @(negedge clk);
            waited++;
        end
        if (!line_oe) return;
        seen = 1'b1;
        for (int i = 1; i < FRAME; i++) begin
            @(negedge clk);
            card_pull = (pull_bit >= 0) && (i / BIT == pull_bit) && (i % BIT != 0);
            if (poke && i == 11 * BIT + 8) begin wr_en = 1'b1; wr_data = poke_byte; end
            if (poke && i == 11 * BIT + 9) wr_en = 1'b0;
            if (i % BIT == BIT / 2) bits[i / BIT] = !line_oe;
            if (i == 15) oe15 = line_oe;
            if (i == 16) oe16 = line_oe;
            if (i == 11 * BIT + 7) irq183 = perr_irq;
            if (i == 11 * BIT + 8) rdy184 = wr_ready;
            if (i == 11 * BIT + 9) begin irq185 = perr_irq; rdy185 = wr_ready; end
        end
        @(negedge clk);
        card_pull = 1'b0;
    endtask

    task automatic check_frame(input logic [7:0] b, input string req);
        logic [11:0] exp;
        exp = {2'b11, ^b, b, 1'b0};
        chk(bits == exp, req, int'(bits), int'(exp));
    endtask

    task automatic expect_quiet(input int cycles, input string req);
        bit drove = 1'b0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (line_oe) drove = 1'b1;
        end
        chk(!drove, req, int'(drove), 0);
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk(line_oe == 1'b0, "R1 line_oe", int'(line_oe), 0);
        chk(bclk_out == 1'b0, "R1 bclk_out", int'(bclk_out), 0);
        chk(perr_irq == 1'b0, "R1 perr_irq", int'(perr_irq), 0);
        chk(wr_ready == 1'b1, "R1 wr_ready", int'(wr_ready), 1);
    endtask

    task automatic t_disabled_then_send;
        bit moved = 1'b0, seen;
        put(8'hA5);
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            if (bclk_out || line_oe) moved = 1'b1;
        end
        chk(!moved, "R2 idle while disabled", int'(moved), 0);
        sc_en = 1'b1;
        recv(-1, 1'b0, 8'h00, seen);
        chk(seen, "R2 queued byte sent after enable", int'(seen), 1);
        check_frame(8'hA5, "R3 frame A5");
        chk(oe15 == 1'b1 && oe16 == 1'b0, "R4 start bit length",
            int'({oe15, oe16}), 2);
    endtask

    task automatic t_bitclk_rate;
        int changes = 0;
        logic prev;
        repeat (4) @(negedge clk);
        prev = bclk_out;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (bclk_out != prev) changes++;
            prev = bclk_out;
        end
        chk(changes == 40 / HALF, "R2 bit clock toggle rate", changes, 40 / HALF);
    endtask

    task automatic t_fifo_order_full;
        logic [7:0] q [4] = '{8'h3C, 8'h01, 8'hFF, 8'h80};
        bit seen;
        @(negedge clk);
        sc_en = 1'b0;
        foreach (q[k]) put(q[k]);
        @(negedge clk);
        chk(wr_ready == 1'b0, "R5 wr_ready low when full", int'(wr_ready), 0);
        put(8'h77);   // must be dropped
        sc_en = 1'b1;
        foreach (q[k]) begin
            recv(-1, 1'b0, 8'h00, seen);
            chk(seen, "R5 character present", int'(seen), 1);
            check_frame(q[k], "R3 R5 frame order");
        end
        expect_quiet(400, "R5 write while full dropped");
    endtask

    task automatic t_stop1_pull;
        bit seen;
        put(8'h5A);
        recv(10, 1'b0, 8'h00, seen);
        check_frame(8'h5A, "R6 frame 5A");
        repeat (4) @(negedge clk);
        chk(perr_irq == 1'b0, "R7 pull in first stop bit ignored", int'(perr_irq), 0);
    endtask

    task automatic t_abort;
        bit seen;
        @(negedge clk);
        sc_en = 1'b0;
        put(8'h11); put(8'h22); put(8'h33);
        sc_en = 1'b1;
        recv(11, 1'b1, 8'h99, seen);
        chk(seen, "R7 character present", int'(seen), 1);
        chk(irq183 == 1'b0, "R7 no error before mid-point", int'(irq183), 0);
        chk(irq185 == 1'b1, "R7 error at mid-point of second stop", int'(irq185), 1);
        chk(rdy184 == 1'b0, "R10 wr_ready low in flush cycle", int'(rdy184), 0);
        chk(rdy185 == 1'b1, "R10 wr_ready back after flush", int'(rdy185), 1);
        expect_quiet(600, "R8 R9 queued bytes discarded, no resend");
        chk(perr_irq == 1'b1, "R9 interrupt sticky", int'(perr_irq), 1);
        @(negedge clk); irq_clr = 1'b1;
        @(negedge clk); irq_clr = 1'b0;
        @(negedge clk);
        chk(perr_irq == 1'b0, "R9 interrupt cleared", int'(perr_irq), 0);
        put(8'h4B);
        recv(-1, 1'b0, 8'h00, seen);
        chk(seen, "R10 write after flush accepted", int'(seen), 1);
        check_frame(8'h4B, "R10 frame 4B");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_disabled_then_send();
        t_bitclk_rate();
        t_fifo_order_full();
        t_stop1_pull();
        t_abort();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule